// File: doc/BRIEF.md
# Self-Refresh Entry and Exit Sequencer

This block walks one stacked-DRAM channel into self-refresh and back out again under host control. When a request arrives while the channel is ready, the block closes every bank and waits out the precharge time. It then issues the self-refresh entry command in the same cycle that it drops clock-enable. Once clock-enable has been low for the minimum hold, it may stop the external memory clock if the host allows that.

A wake request starts a timed handover. If the clock was stopped, the block restarts it and keeps clock-enable low while it settles. It then raises clock-enable and holds the channel in a no-command window for the full exit time. Inside that window it may slot one short impedance calibration command. A remaining-latency count tells the host exactly how many cycles are left before commands may resume, so the host can insert precise wait states.

Top module: `selfref_seq`

## Requirements
- R1: An asynchronous active-low reset drives cke=1, clk_gate=0, ready=1, cmd_valid=0, lat_remain=0 and phase=0 (IDLE) while reset is low. This takes effect at once, without waiting for a clock edge, even in the middle of self-refresh.
- R2: A cycle in IDLE with sr_req=1 and wake_req=0 causes the close-all-banks command (code 1) to be presented in the next cycle. ready falls in that same next cycle and phase reads 1 (PRECHARGE).
- R3: The self-refresh entry command (code 2) is presented exactly T_RP cycles after the close-all command. It appears in the first cycle with cke=0, and phase then reads 2 (SR_ENTER).
- R4: clk_gate rises only when all of the following hold: clk_stop_allow=1, no wake is pending, and cke has already been low for at least T_CKESR cycles. Phase reads 3 (SR_CLOCK_STOPPED) while the clock is gated, and clk_gate=1 never coincides with cke=1.
- R5: A wake_req while the clock is gated drops clk_gate in the next cycle. cke then stays low for T_CKSRX more cycles with phase 4 (SR_CLK_RESTART), and after that cke rises.
- R6: ready stays low for exactly T_XS cycles, counted from the cycle cke rises, with phase 5 (SR_EXIT_WAIT). After that, ready=1 and phase=0.
- R7: In phases 4 and 5, lat_remain equals the number of cycles until ready rises, and it drops by one every cycle. In all other phases it reads 0.
- R8: A wake_req during PRECHARGE, including its last cycle, aborts entry. In the next cycle phase=0 and ready=1, and no entry command is ever issued.
- R9: A wake_req after the entry command but while the clock is still running is held until the T_CKESR hold ends. cke then rises with no settle phase, at the later of the cycle after the wake and the cycle after the hold ends, and lat_remain equals T_XS in that cycle. A wake in the last hold cycle takes precedence over stopping the clock.
- R10: sr_req is ignored outside IDLE, and it is also ignored in IDLE when wake_req is high in the same cycle. In either case no command is issued and the phase is unchanged.
- R11: When cmd_valid=0, cmd reads 0 (NOP). Each command is presented for a single cycle. The phase codes are IDLE=0, PRECHARGE=1, SR_ENTER=2, SR_CLOCK_STOPPED=3, SR_CLK_RESTART=4 and SR_EXIT_WAIT=5.
- R12: With zq_cal_en=1, exactly one short calibration command (code 3) is presented, ZQ_SLOT cycles after cke rises. Every other cycle of the exit window carries no command, and with zq_cal_en=0 the whole window carries none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | Request to enter self-refresh, sampled in IDLE |
| wake_req | input | 1 | Request to leave self-refresh or abort entry |
| clk_stop_allow | input | 1 | Permits stopping the external memory clock |
| zq_cal_en | input | 1 | Enables one calibration command in the exit window |
| cmd_valid | output | 1 | Single-cycle strobe for cmd |
| cmd | output | 2 | Command code: 0 NOP, 1 close all banks, 2 self-refresh entry, 3 short calibration |
| cke | output | 1 | Clock-enable to the memory |
| clk_gate | output | 1 | 1 while the external memory clock is stopped |
| ready | output | 1 | Channel may accept commands |
| lat_remain | output | LAT_W | Cycles left until ready during exit, else 0 |
| phase | output | 3 | Current phase code |

## Verification
The bench targets the edges of each timed wait:
- **Wake at the last precharge cycle.** A design with the wrong priority would still emit the entry command there.
- **Wake during the clock-enable hold.** A design that raised cke early would break the minimum low time.
- **Wake in the final hold cycle while clock stopping is allowed.** A design with the wrong priority would gate the clock and then pay a needless settle delay.

Throughout the exit window the bench follows the latency count cycle by cycle. An off-by-one in the count would show up as a gap or a repeated value where the settle phase hands over to the exit wait. The bench also checks that a request arriving mid-sequence cannot restart entry.

// File: rtl/selfref_pkg.sv
`timescale 1ns/1ps
package selfref_pkg;

  typedef enum logic [2:0] {
    PH_IDLE        = 3'd0,
    PH_PRECHARGE   = 3'd1,
    PH_ENTER       = 3'd2,
    PH_CLK_STOPPED = 3'd3,
    PH_CLK_RESTART = 3'd4,
    PH_EXIT_WAIT   = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    CMD_NOP       = 2'd0,
    CMD_CLOSE_ALL = 2'd1,
    CMD_SR_ENTER  = 2'd2,
    CMD_ZQ_SHORT  = 2'd3
  } cmd_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Counter width able to hold v, never below 10 bits.
  function automatic int unsigned width_for(input int unsigned v);
    int unsigned w;
    w = $clog2(v + 1);
    return (w < 10) ? 10 : w;
  endfunction

  // Cycles left until ready, given the phase and the phase timer.
  function automatic int unsigned remaining(input phase_e ph, input int unsigned tmr,
                                            input int unsigned t_xs);
    case (ph)
      PH_CLK_RESTART: return tmr + 1 + t_xs;
      PH_EXIT_WAIT:   return tmr + 1;
      default:        return 0;
    endcase
  endfunction

endpackage

// File: rtl/selfref_timer.sv
`timescale 1ns/1ps
module selfref_timer #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);

  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (!zero) cnt <= cnt - 1'b1;
  end

  // Once loaded, the count moves by exactly one per cycle until it rests at zero.
  p_tmr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt + 1'b1 == $past(cnt)));

endmodule

// File: rtl/selfref_ctrl.sv
`timescale 1ns/1ps
module selfref_ctrl
  import selfref_pkg::*;
#(
  parameter int unsigned T_RP    = 10,
  parameter int unsigned T_CKESR = 4,
  parameter int unsigned T_CKSRX = 8,
  parameter int unsigned T_XS    = 512,
  parameter int unsigned ZQ_SLOT = 1,
  parameter int unsigned TW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sr_req,
  input  logic          wake_req,
  input  logic          clk_stop_allow,
  input  logic          zq_cal_en,
  input  logic          tmr_zero,
  input  logic [TW-1:0] tmr_val,
  output phase_e        ph,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_load_val,
  output logic          cmd_valid,
  output cmd_e          cmd
);

  localparam logic [TW-1:0] L_RP    = TW'(T_RP - 1);
  localparam logic [TW-1:0] L_CKESR = TW'(T_CKESR - 1);
  localparam logic [TW-1:0] L_CKSRX = TW'(T_CKSRX - 1);
  localparam logic [TW-1:0] L_XS    = TW'(T_XS - 1);
  localparam logic [TW-1:0] ZQ_AT   = TW'(T_XS - ZQ_SLOT);

  phase_e ph_n;
  cmd_e   cmd_n;
  logic   cv_n;
  logic   pend, pend_n;

  // Named internal events
  logic hold_done, settle_done, exit_done, zq_slot;
  assign hold_done   = (ph == PH_ENTER)       && tmr_zero;
  assign settle_done = (ph == PH_CLK_RESTART) && tmr_zero;
  assign exit_done   = (ph == PH_EXIT_WAIT)   && tmr_zero;
  assign zq_slot     = (ph == PH_EXIT_WAIT)   && zq_cal_en && (tmr_val == ZQ_AT);

  always_comb begin
    ph_n         = ph;
    pend_n       = pend;
    tmr_load     = 1'b0;
    tmr_load_val = '0;
    cmd_n        = CMD_NOP;
    cv_n         = 1'b0;
    unique case (ph)
      PH_IDLE: begin
        pend_n = 1'b0;
        if (sr_req && !wake_req) begin
          ph_n         = PH_PRECHARGE;
          tmr_load     = 1'b1;
          tmr_load_val = L_RP;
          cv_n         = 1'b1;
          cmd_n        = CMD_CLOSE_ALL;
        end
      end
      PH_PRECHARGE: begin
        if (wake_req) begin
          ph_n = PH_IDLE;
        end else if (tmr_zero) begin
          ph_n         = PH_ENTER;
          tmr_load     = 1'b1;
          tmr_load_val = L_CKESR;
          cv_n         = 1'b1;
          cmd_n        = CMD_SR_ENTER;
        end
      end
      PH_ENTER: begin
        if (wake_req) pend_n = 1'b1;
        if (hold_done) begin
          if (pend || wake_req) begin
            ph_n         = PH_EXIT_WAIT;
            tmr_load     = 1'b1;
            tmr_load_val = L_XS;
            pend_n       = 1'b0;
          end else if (clk_stop_allow) begin
            ph_n = PH_CLK_STOPPED;
          end
        end
      end
      PH_CLK_STOPPED: begin
        if (wake_req) begin
          ph_n         = PH_CLK_RESTART;
          tmr_load     = 1'b1;
          tmr_load_val = L_CKSRX;
        end
      end
      PH_CLK_RESTART: begin
        if (settle_done) begin
          ph_n         = PH_EXIT_WAIT;
          tmr_load     = 1'b1;
          tmr_load_val = L_XS;
        end
      end
      PH_EXIT_WAIT: begin
        if (zq_slot) begin
          cv_n  = 1'b1;
          cmd_n = CMD_ZQ_SHORT;
        end
        if (exit_done) ph_n = PH_IDLE;
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      pend      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd       <= CMD_NOP;
    end else begin
      ph        <= ph_n;
      pend      <= pend_n;
      cmd_valid <= cv_n;
      cmd       <= cmd_n;
    end
  end

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_PRECHARGE && wake_req) |=> (ph == PH_IDLE && !cmd_valid));

  p_exit_only_zq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_EXIT_WAIT && cmd_valid) |-> (cmd == CMD_ZQ_SHORT));

  p_nop_when_invalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (cmd == CMD_NOP));

  p_busy_ignores_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE && sr_req) |=> !(cmd_valid && cmd == CMD_CLOSE_ALL));

endmodule

// File: rtl/selfref_seq.sv
`timescale 1ns/1ps
module selfref_seq #(
  parameter  int unsigned T_RP    = 10,
  parameter  int unsigned T_CKESR = 4,
  parameter  int unsigned T_CKSRX = 8,
  parameter  int unsigned T_XS    = 512,
  parameter  int unsigned ZQ_SLOT = 1,
  localparam int unsigned LAT_W   = selfref_pkg::width_for(T_CKSRX + T_XS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_req,
  input  logic             wake_req,
  input  logic             clk_stop_allow,
  input  logic             zq_cal_en,
  output logic             cmd_valid,
  output logic [1:0]       cmd,
  output logic             cke,
  output logic             clk_gate,
  output logic             ready,
  output logic [LAT_W-1:0] lat_remain,
  output logic [2:0]       phase
);
  import selfref_pkg::*;

  localparam int unsigned TMAX = max_of(max_of(T_RP, T_CKESR), max_of(T_CKSRX, T_XS));
  localparam int unsigned TW   = width_for(TMAX);

  phase_e        ph;
  cmd_e          cmd_q;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_load_val, tmr_val;

  selfref_ctrl #(
    .T_RP(T_RP), .T_CKESR(T_CKESR), .T_CKSRX(T_CKSRX),
    .T_XS(T_XS), .ZQ_SLOT(ZQ_SLOT), .TW(TW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .wake_req(wake_req),
    .clk_stop_allow(clk_stop_allow), .zq_cal_en(zq_cal_en),
    .tmr_zero(tmr_zero), .tmr_val(tmr_val), .ph(ph),
    .tmr_load(tmr_load), .tmr_load_val(tmr_load_val),
    .cmd_valid(cmd_valid), .cmd(cmd_q)
  );

  selfref_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_load_val),
    .cnt(tmr_val), .zero(tmr_zero)
  );

  assign cmd        = cmd_q;
  assign phase      = ph;
  assign cke        = !(ph inside {PH_ENTER, PH_CLK_STOPPED, PH_CLK_RESTART});
  assign clk_gate   = (ph == PH_CLK_STOPPED);
  assign ready      = (ph == PH_IDLE);
  assign lat_remain = LAT_W'(remaining(ph, 32'(tmr_val), T_XS));

  // Checker state: cycles cke has been low, saturating.
  logic [TW-1:0] cke_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cke_low_cnt <= '0;
    else if (cke)               cke_low_cnt <= '0;
    else if (cke_low_cnt != '1) cke_low_cnt <= cke_low_cnt + 1'b1;
  end

  p_entry_with_cke_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 2'd2) |-> (!cke && $past(cke)));

  p_gate_needs_cke_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate |-> !cke);

  p_gate_after_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate) |-> (cke_low_cnt >= TW'(T_CKESR)));

  p_restart_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_gate) |-> (!cke && lat_remain == LAT_W'(T_CKSRX + T_XS)));

  p_ready_no_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (lat_remain == '0));

  p_latency_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_remain != '0) |=> (lat_remain + 1'b1 == $past(lat_remain)));

  p_direct_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cke) && $past(ph) == PH_ENTER) |-> (lat_remain == LAT_W'(T_XS)));

endmodule

// File: tb/selfref_seq_tb.sv
`timescale 1ns/1ps
module selfref_seq_tb;

  localparam int RP = 4, CKESR = 3, CKSRX = 5, XS = 20, ZQS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sr_req = 1'b0, wake_req = 1'b0, stop_ok = 1'b0, zq_en = 1'b0;
  logic cmd_valid, cke, clk_gate, ready;
  logic [1:0] cmd;
  logic [9:0] lat;
  logic [2:0] phase;

  int  checks = 0, errors = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  selfref_seq #(.T_RP(RP), .T_CKESR(CKESR), .T_CKSRX(CKSRX), .T_XS(XS), .ZQ_SLOT(ZQS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .wake_req(wake_req),
    .clk_stop_allow(stop_ok), .zq_cal_en(zq_en), .cmd_valid(cmd_valid), .cmd(cmd),
    .cke(cke), .clk_gate(clk_gate), .ready(ready), .lat_remain(lat), .phase(phase)
  );

  // Scenario table: stop permitted, calibration on, wake cycle, expected cke rise (-1 = abort)
  localparam int NV = 7;
  localparam int V_STOP [NV] = '{1, 0, 0, 1, 0, 0, 1};
  localparam int V_ZQ   [NV] = '{1, 0, 1, 0, 0, 0, 0};
  localparam int V_WAKE [NV] = '{12, 5, 15, 7, 2, 3, 6};
  localparam int V_RISE [NV] = '{18, 7, 16, 13, -1, -1, 7};

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    int  w, rise, last, ex_start, cv_e, ph_e, lat_e;
    bit  abort, gated, cke_e, gate_e, rdy_e;
    string ctag;
    w     = V_WAKE[i];
    rise  = V_RISE[i];
    abort = (rise < 0);
    gated = (V_STOP[i] != 0) && (w >= RP + CKESR);
    last  = abort ? w + 3 : rise + XS + 2;
    stop_ok = (V_STOP[i] != 0);
    zq_en   = (V_ZQ[i] != 0);
    sr_req  = 1'b1;
    for (int c = 0; c <= last; c++) begin
      @(negedge clk);
      sr_req = 1'b0;
      if (abort) begin
        cke_e = 1'b1; gate_e = 1'b0; rdy_e = (c > w); lat_e = 0;
        ph_e  = (c <= w) ? 1 : 0;
        cv_e  = (c == 0) ? 5 : 0;
        chk("R8", "cke", cke, cke_e);
        chk("R8", "ready", ready, rdy_e);
        chk("R8", "phase", phase, ph_e);
        chk(c == 0 ? "R2" : "R8", "cmd", {cmd_valid, cmd}, cv_e);
        chk("R7", "lat", lat, lat_e);
      end else begin
        cke_e  = (c < RP) || (c >= rise);
        gate_e = gated && (c >= RP + CKESR) && (c <= w);
        rdy_e  = (c >= rise + XS);
        ex_start = gated ? w + 1 : rise;
        lat_e  = (c >= ex_start && c < rise + XS) ? rise + XS - c : 0;
        if (c < RP)                                ph_e = 1;
        else if (c < rise && !gated)               ph_e = 2;
        else if (c < rise && c < RP + CKESR)       ph_e = 2;
        else if (c < rise && c <= w)               ph_e = 3;
        else if (c < rise)                         ph_e = 4;
        else if (c < rise + XS)                    ph_e = 5;
        else                                       ph_e = 0;
        if (c == 0)                                cv_e = 5;
        else if (c == RP)                          cv_e = 6;
        else if (zq_en && c == rise + ZQS)         cv_e = 7;
        else                                       cv_e = 0;
        ctag = (c == 0) ? "R2" : (c == RP) ? "R3" : (c >= rise) ? "R12" : "R11";
        chk(gated ? "R5" : ((w < RP + CKESR) ? "R9" : "R3"), "cke", cke, cke_e);
        chk("R4", "clk_gate", clk_gate, gate_e);
        chk("R6", "ready", ready, rdy_e);
        chk("R7", "lat", lat, lat_e);
        chk("R11", "phase", phase, ph_e);
        chk(ctag, "cmd", {cmd_valid, cmd}, cv_e);
      end
      wake_req = (c == w);
    end
    wake_req = 1'b0;
    stop_ok  = 1'b0;
    zq_en    = 1'b0;
  endtask

  initial begin
    // R1: state held in reset
    repeat (3) @(negedge clk);
    chk("R1", "cke", cke, 1);
    chk("R1", "clk_gate", clk_gate, 0);
    chk("R1", "ready", ready, 1);
    chk("R1", "cmd_valid", cmd_valid, 0);
    chk("R1", "phase", phase, 0);
    chk("R1", "lat", lat, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after release", ready, 1);

    for (int i = 0; i < NV; i++) begin
      run_vec(i);
      repeat (2) @(negedge clk);
    end

    // R10: request together with wake in IDLE
    sr_req = 1'b1; wake_req = 1'b1;
    @(negedge clk);
    sr_req = 1'b0; wake_req = 1'b0;
    chk("R10", "phase", phase, 0);
    chk("R10", "cmd", {cmd_valid, cmd}, 0);
    chk("R10", "ready", ready, 1);

    // R10: request while gated and during exit window
    stop_ok = 1'b1; sr_req = 1'b1;
    @(negedge clk);
    sr_req = 1'b0;
    repeat (9) @(negedge clk);
    sr_req = 1'b1;
    @(negedge clk);
    sr_req = 1'b0;
    chk("R10", "phase while gated", phase, 3);
    chk("R10", "cmd while gated", {cmd_valid, cmd}, 0);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    chk("R5", "clk_gate after wake", clk_gate, 0);
    chk("R5", "phase after wake", phase, 4);
    repeat (7) @(negedge clk);
    sr_req = 1'b1;
    @(negedge clk);
    sr_req = 1'b0;
    chk("R10", "phase in exit", phase, 5);
    chk("R10", "cmd in exit", {cmd_valid, cmd}, 0);
    chk("R7", "lat in exit", lat, 17);
    repeat (17) @(negedge clk);
    chk("R6", "ready after exit", ready, 1);
    chk("R7", "lat after exit", lat, 0);
    stop_ok = 1'b0;

    // R1: asynchronous reset in the middle of self-refresh
    stop_ok = 1'b1; sr_req = 1'b1;
    @(negedge clk);
    sr_req = 1'b0;
    repeat (9) @(negedge clk);
    chk("R4", "gated before reset", clk_gate, 1);
    rst_n = 1'b0;
    #3;
    chk("R1", "async cke", cke, 1);
    chk("R1", "async clk_gate", clk_gate, 0);
    chk("R1", "async ready", ready, 1);
    chk("R1", "async phase", phase, 0);
    @(negedge clk);
    rst_n = 1'b1; stop_ok = 1'b0;
    @(negedge clk);
    chk("R1", "idle after reset", phase, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule